// File: doc/BRIEF.md
# Split-Edge Bus-Invert Output Driver

This block sits between internal logic and a bank of output pins. It takes one data word per clock and drives it out through registers only, so no combinational glitch can reach a pin. To spread the switching current over time, the word is cut into a lower half and an upper half. The lower half is launched on the rising clock edge. The upper half of the same word is launched on the falling edge that follows.

Each half may be bus-invert coded. When more than half of a half's bits would change, the complement is sent instead, and that half's flag is raised. A static polarity input inverts every data bit as well. This lets the bus rest at whichever level draws less pad current. Per-bit output enables follow the word valid, so pins are driven only while they carry data. While no data is valid, the data registers do not toggle.

A receiver recovers each half as `pad ^ {pol} ^ {flag}`, using that half's flag and the polarity that applied when the word was sent.

Top module: `stagger_bus_drv`

## Requirements
- R1: While reset is asserted and after its release, before any valid word, `pad_o`, `pad_oe_o` and `inv_o` are all zero.
- R2: A word sampled with `valid_i`=1 on a rising edge appears as follows. The lower half (`pad_o[H-1:0]`, H = DATA_W/2) and `inv_o[0]` update on that rising edge. The upper half (`pad_o[DATA_W-1:H]`) and `inv_o[1]` keep their old value until the next falling edge, where they update.
- R3: For every valid word, each half satisfies `data = pad ^ {H{pol_i}} ^ {H{inv flag}}`. Here `inv_o[0]` belongs to the lower half, `inv_o[1]` to the upper half, and `pol_i` is the value sampled with the word.
- R4: With `enc_en_i`=1, a half's flag is 1 exactly when `data ^ {H{pol_i}}` differs from that half's current pin value in more than H/2 bits. When the flag is 1, the complement is driven. Hence at most H/2 data pins of a half toggle per word.
- R5: With `enc_en_i`=0, the flag of the half is 0 and the half drives `data ^ {H{pol_i}}`.
- R6: With `pol_i`=1, every data bit is inverted on top of the bus-invert coding. An all-zero word with coding off drives all ones.
- R7: The enable bits of a half are all 1 after the edge of that half that launches a valid word. They are all 0 after the edge of that half that follows a rising edge sampling `valid_i`=0. This is one cycle after valid drops.
- R8: A word sampled with `valid_i`=0 leaves `pad_o` and `inv_o` unchanged, whatever `data_i`, `enc_en_i` and `pol_i` hold.
- R9: A half whose change count equals exactly H/2 is sent uninverted, with its flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; lower half on rising edge, upper half on falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Word on `data_i` is valid |
| data_i | input | DATA_W | Word to drive |
| enc_en_i | input | 1 | Enable bus-invert coding |
| pol_i | input | 1 | Static polarity: 1 inverts all data bits |
| pad_o | output | DATA_W | Registered pin data |
| pad_oe_o | output | DATA_W | Per-bit output enable |
| inv_o | output | 2 | Invert flags, bit 0 lower half, bit 1 upper half |

## Verification
The bench aims at the tie point where exactly H/2 bits would change. A design with the wrong comparison would invert there and raise a flag that should stay low. It checks that the upper half still shows the previous word just after the rising edge. A design that launched both halves on one edge, and so lost the stagger, would fail that check. It also sends invalid words that carry fresh data, polarity and coding settings. A design that let them through would toggle held pins. Every valid word is decoded from the pins and flags, so a polarity or flag applied to the wrong half shows up as a corrupted word.

// File: rtl/stagger_pkg.sv
package stagger_pkg;
  typedef struct packed {
    logic vld;
    logic enc;
    logic pol;
  } lane_ctl_t;
endpackage

// File: rtl/stagger_bi_encoder.sv
module stagger_bi_encoder #(
  parameter int W = 8
) (
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] data_i,
  input  logic         enc_en_i,
  input  logic         pol_i,
  output logic [W-1:0] word_o,
  output logic         flag_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(W / 2);

  logic [W-1:0]  base;
  logic [W-1:0]  diff;
  logic [CW-1:0] cnt;

  assign base = data_i ^ {W{pol_i}};
  assign diff = base ^ prev_i;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(diff[i]);
  end

  // strict majority only: a tie stays uninverted
  assign flag_o = enc_en_i && (cnt > HALF_CNT);
  assign word_o = flag_o ? ~base : base;
endmodule

// File: rtl/stagger_half_lane.sv
module stagger_half_lane
  import stagger_pkg::*;
#(
  parameter int W         = 8,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  lane_ctl_t    ctl_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] pad_o,
  output logic         oe_o,
  output logic         inv_o
);
  logic [W-1:0] pad_q;
  logic [W-1:0] nxt_word;
  logic         nxt_flag;

  stagger_bi_encoder #(.W(W)) u_enc (
    .prev_i  (pad_q),
    .data_i  (data_i),
    .enc_en_i(ctl_i.enc),
    .pol_i   (ctl_i.pol),
    .word_o  (nxt_word),
    .flag_o  (nxt_flag)
  );

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pad_q <= '0;
          inv_o <= 1'b0;
          oe_o  <= 1'b0;
        end else begin
          oe_o <= ctl_i.vld;
          if (ctl_i.vld) begin
            pad_q <= nxt_word;
            inv_o <= nxt_flag;
          end
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pad_q <= '0;
          inv_o <= 1'b0;
          oe_o  <= 1'b0;
        end else begin
          oe_o <= ctl_i.vld;
          if (ctl_i.vld) begin
            pad_q <= nxt_word;
            inv_o <= nxt_flag;
          end
        end
      end
    end
  endgenerate

  assign pad_o = pad_q;
endmodule

// File: rtl/stagger_bus_drv.sv
module stagger_bus_drv
  import stagger_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              enc_en_i,
  input  logic              pol_i,
  output logic [DATA_W-1:0] pad_o,
  output logic [DATA_W-1:0] pad_oe_o,
  output logic [1:0]        inv_o
);
  localparam int H = DATA_W / 2;

  lane_ctl_t      lo_ctl;
  lane_ctl_t      hi_ctl_q;
  logic [H-1:0]   hi_data_q;
  logic [H-1:0]   lo_pad;
  logic [H-1:0]   hi_pad;
  logic           lo_oe;
  logic           hi_oe;

  assign lo_ctl = '{vld: valid_i, enc: enc_en_i, pol: pol_i};

  // upper half of the word is captured with the lower half, launched half a cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_ctl_q  <= '0;
      hi_data_q <= '0;
    end else begin
      hi_ctl_q <= lo_ctl;
      if (valid_i) hi_data_q <= data_i[DATA_W-1:H];
    end
  end

  stagger_half_lane #(.W(H), .FALL_EDGE(1'b0)) u_lo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctl_i (lo_ctl),
    .data_i(data_i[H-1:0]),
    .pad_o (lo_pad),
    .oe_o  (lo_oe),
    .inv_o (inv_o[0])
  );

  stagger_half_lane #(.W(H), .FALL_EDGE(1'b1)) u_hi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctl_i (hi_ctl_q),
    .data_i(hi_data_q),
    .pad_o (hi_pad),
    .oe_o  (hi_oe),
    .inv_o (inv_o[1])
  );

  assign pad_o    = {hi_pad, lo_pad};
  assign pad_oe_o = {{H{hi_oe}}, {H{lo_oe}}};
endmodule

// File: rtl/stagger_bus_drv_chk.sv
module stagger_bus_drv_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              enc_en_i,
  input logic              pol_i,
  input logic [DATA_W-1:0] pad_o,
  input logic [DATA_W-1:0] pad_oe_o,
  input logic [1:0]        inv_o
);
  localparam int H = DATA_W / 2;

  p_lo_decode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((pad_o[H-1:0] ^ {H{inv_o[0]}} ^ {H{$past(pol_i)}}) == $past(data_i[H-1:0])));

  p_hi_decode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((pad_o[DATA_W-1:H] ^ {H{inv_o[1]}} ^ {H{$past(pol_i)}}) == $past(data_i[DATA_W-1:H])));

  p_lo_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enc_en_i) |=> ($countones(pad_o[H-1:0] ^ $past(pad_o[H-1:0])) <= H / 2));

  p_hi_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enc_en_i) |=> ($countones(pad_o[DATA_W-1:H] ^ $past(pad_o[DATA_W-1:H])) <= H / 2));

  p_plain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !enc_en_i) |=> (inv_o == 2'b00));

  p_oe_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (&pad_oe_o));

  p_oe_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (pad_oe_o == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pad_o) && $stable(inv_o)));
endmodule

bind stagger_bus_drv stagger_bus_drv_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_stagger_bus_drv.sv
`timescale 1ns/1ps
module sim_stagger_bus_drv;
  localparam int DATA_W = 16;
  localparam int H = DATA_W / 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              enc_en_i = 1'b0;
  logic              pol_i = 1'b0;
  logic [DATA_W-1:0] pad_o;
  logic [DATA_W-1:0] pad_oe_o;
  logic [1:0]        inv_o;

  int total = 0;
  int fails = 0;

  logic [H-1:0] m_lo = '0, m_hi = '0;
  logic         m_f0 = 1'b0, m_f1 = 1'b0, m_oe0 = 1'b0, m_oe1 = 1'b0;

  always #2.5 clk_i = ~clk_i;

  stagger_bus_drv #(.DATA_W(DATA_W)) u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference bus-invert: {flag, word}
  function automatic logic [H:0] ref_enc(input logic [H-1:0] prev, input logic [H-1:0] d,
                                         input logic e, input logic p);
    logic [H-1:0] b;
    int n;
    b = p ? ~d : d;
    n = 0;
    for (int i = 0; i < H; i++) if (b[i] != prev[i]) n++;
    if (e && n > H / 2) return {1'b1, ~b};
    return {1'b0, b};
  endfunction

  task automatic step(input logic v, input logic [DATA_W-1:0] d, input logic e, input logic p);
    string tag;
    valid_i = v; data_i = d; enc_en_i = e; pol_i = p;
    tag = !v ? "R8" : (e ? "R4" : "R5");
    @(posedge clk_i); #1;
    check("R2 upper holds after rise", {56'd0, pad_o[DATA_W-1:H]}, {56'd0, m_hi});
    if (v) {m_f0, m_lo} = ref_enc(m_lo, d[H-1:0], e, p);
    m_oe0 = v;
    check(tag, {56'd0, pad_o[H-1:0]}, {56'd0, m_lo});
    check(tag, {63'd0, inv_o[0]}, {63'd0, m_f0});
    check("R7", {56'd0, pad_oe_o[H-1:0]}, {56'd0, {H{m_oe0}}});
    @(negedge clk_i); #1;
    if (v) {m_f1, m_hi} = ref_enc(m_hi, d[DATA_W-1:H], e, p);
    m_oe1 = v;
    check(tag, {56'd0, pad_o[DATA_W-1:H]}, {56'd0, m_hi});
    check(tag, {63'd0, inv_o[1]}, {63'd0, m_f1});
    check("R7", {56'd0, pad_oe_o[DATA_W-1:H]}, {56'd0, {H{m_oe1}}});
    if (v) check("R3 decode", {48'd0, pad_o ^ {DATA_W{p}} ^ {{H{inv_o[1]}}, {H{inv_o[0]}}}}, {48'd0, d});
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    #3;
    check("R1 pad in reset", {48'd0, pad_o}, 64'd0);
    check("R1 oe in reset", {48'd0, pad_oe_o}, 64'd0);
    #9.5 rst_ni = 1'b1;
    #1;
    check("R1 pad after reset", {48'd0, pad_o}, 64'd0);
    check("R1 inv after reset", {62'd0, inv_o}, 64'd0);
    @(negedge clk_i); #1;

    step(1'b1, 16'h0000, 1'b1, 1'b0);
    step(1'b1, 16'h0F0F, 1'b1, 1'b0);
    check("R9 tie no invert", {62'd0, inv_o}, 64'd0);
    check("R9 tie word", {48'd0, pad_o}, 64'h0F0F);
    step(1'b1, 16'hF0F0, 1'b1, 1'b0);
    check("R4 invert taken", {62'd0, inv_o}, 64'd3);
    check("R4 no toggle", {48'd0, pad_o}, 64'h0F0F);
    step(1'b1, 16'h0000, 1'b0, 1'b1);
    check("R6 polarity", {48'd0, pad_o}, 64'hFFFF);
    step(1'b0, 16'hA5A5, 1'b1, 1'b0);
    check("R8 held", {48'd0, pad_o}, 64'hFFFF);
    check("R7 oe off", {48'd0, pad_oe_o}, 64'd0);
    step(1'b0, 16'h1234, 1'b0, 1'b1);

    for (int k = 0; k < 400; k++) begin
      step(($urandom % 4) != 0, 16'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule